// File: doc/BRIEF.md
# Configuration Access and Security Controller

This block sits between a programming port and the configuration storage of a programmable logic device. It accepts one command per handshake and acts on a fuse word array and a 64-bit user signature. Both stores are modelled as plain registers. The commands write or verify a fuse word, force a value into the device's registers (preload), read or write a signature byte, set the security bit, and erase everything.

Each accepted command produces exactly one response. The response carries read data and a blocked flag. The security bit is a one-way latch, and it applies from the very next accepted command. While it is set, fuse read-back and preload are refused. Fuse writes and all signature traffic still work. Only the erase command clears the bit, and erase also clears every fuse word and every signature byte.

Top module: `cfgsec_ctrl`

## Requirements
- R1: After reset there is no pending response and no preload pulse, `cmd_ready` is high, the security bit is clear, and every fuse word and signature byte reads as zero.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` equals `!rsp_valid || rsp_ready`. The response appears on the next cycle. While `rsp_ready` is low, the response's valid, data and blocked flag hold unchanged. The opcode `cmd_op` is encoded as follows: 0 fuse write, 1 fuse read, 2 preload, 3 signature read, 4 signature write, 5 secure, 6 erase.
- R3: A fuse write stores `cmd_wdata` at fuse word `cmd_addr`. Its response is not blocked and carries zero data.
- R4: While security is clear, a fuse read returns the word stored at `cmd_addr`, not blocked.
- R5: The signature has 8 bytes, and `cmd_addr[2:0]` selects the byte. A signature write stores `cmd_wdata[7:0]`. A signature read returns that byte zero-extended. Neither is ever blocked, whether or not security is set.
- R6: The secure command sets the security bit, and the bit stays set until an erase. The command accepted right after the secure command already sees the bit set.
- R7: While security is set, a fuse read returns blocked = 1 with all-zero data.
- R8: While security is clear, a preload gives a not-blocked zero-data response and, in the same cycle, a one-cycle `preload_valid` pulse with `preload_value = cmd_wdata[NREG-1:0]`. While security is set, the preload response is blocked with zero data and no pulse appears.
- R9: While security is set, a fuse write is still accepted, not blocked, and stored.
- R10: Erase clears the security bit, all fuse words and all signature bytes. Its response is not blocked and carries zero data.
- R11: Opcode 7 gives a not-blocked zero-data response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | FUSE_AW (5) | Fuse word index, or signature byte in bits [2:0] |
| cmd_wdata | input | DATA_W (32) | Write data or preload value |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | DATA_W (32) | Read data, zero when blocked |
| rsp_blocked | output | 1 | Command refused by security |
| preload_valid | output | 1 | One-cycle preload strobe |
| preload_value | output | NREG (10) | Register values to force |

## Verification
Two things can fall in the same cycle: the drain of one response and the acceptance of the next command. A stalled response can also coincide with a new command that is offered but refused. Both cases are provoked by holding `rsp_ready` low and then releasing it while `cmd_valid` stays high. They are judged by comparing `cmd_ready` and the response registers against a behavioural model on every clock. The bench also issues secure followed at once by fuse read and preload, to show that the latch bites on the very next command. Signature access in the same window must still pass.

// File: rtl/cfgsec_pkg.sv
package cfgsec_pkg;
    typedef enum logic [2:0] {
        OP_FUSE_WR = 3'd0,
        OP_FUSE_RD = 3'd1,
        OP_PRELOAD = 3'd2,
        OP_SIG_RD  = 3'd3,
        OP_SIG_WR  = 3'd4,
        OP_SECURE  = 3'd5,
        OP_ERASE   = 3'd6,
        OP_NONE    = 3'd7
    } op_e;

    localparam int SIG_BITS = 64;
    localparam int SIG_BYTES = SIG_BITS / 8;
endpackage

// File: rtl/cfgsec_fuse_store.sv
module cfgsec_fuse_store #(
    parameter int AW = 5,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          clr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int WORDS = 1 << AW;

    logic [W-1:0] mem_q [WORDS];
    logic [W-1:0] mem_d [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = clr ? '0 : mem_q[i];
        end
        if (we && !clr) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[addr];

    // R3
    fuse_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we && !clr |=> mem_q[$past(addr)] == $past(wdata));
endmodule

// File: rtl/cfgsec_sig_store.sv
module cfgsec_sig_store
    import cfgsec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       clr,
    input  logic [$clog2(SIG_BYTES)-1:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    logic [SIG_BITS-1:0] sig_d, sig_q;

    always_comb begin
        sig_d = sig_q;
        if (clr) begin
            sig_d = '0;
        end else if (we) begin
            sig_d[idx*8 +: 8] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign rdata = sig_q[idx*8 +: 8];

    // R10
    sig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> sig_q == '0);
endmodule

// File: rtl/cfgsec_ctrl.sv
module cfgsec_ctrl
    import cfgsec_pkg::*;
#(
    parameter int FUSE_AW = 5,
    parameter int DATA_W  = 32,
    parameter int NREG    = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [2:0]         cmd_op,
    input  logic [FUSE_AW-1:0] cmd_addr,
    input  logic [DATA_W-1:0]  cmd_wdata,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               rsp_blocked,
    output logic               preload_valid,
    output logic [NREG-1:0]    preload_value
);
    localparam int IDX_W = $clog2(SIG_BYTES);

    typedef struct packed {
        logic              sec;
        logic              rv;
        logic              blk;
        logic [DATA_W-1:0] rdata;
        logic              plv;
        logic [NREG-1:0]   plval;
    } state_t;

    state_t st_d, st_q;
    op_e    op;
    logic   acc;
    logic   fuse_we, fuse_clr, sig_we, sig_clr;
    logic [DATA_W-1:0] fuse_rdata;
    logic [7:0]        sig_rdata;

    cfgsec_fuse_store #(.AW(FUSE_AW), .W(DATA_W)) u_fuse (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fuse_we),
        .clr   (fuse_clr),
        .addr  (cmd_addr),
        .wdata (cmd_wdata),
        .rdata (fuse_rdata)
    );

    cfgsec_sig_store u_sig (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sig_we),
        .clr   (sig_clr),
        .idx   (cmd_addr[IDX_W-1:0]),
        .wdata (cmd_wdata[7:0]),
        .rdata (sig_rdata)
    );

    assign op        = op_e'(cmd_op);
    assign cmd_ready = !st_q.rv || rsp_ready;
    assign acc       = cmd_valid && cmd_ready;

    always_comb begin
        st_d     = st_q;
        st_d.plv = 1'b0;
        fuse_we  = 1'b0;
        fuse_clr = 1'b0;
        sig_we   = 1'b0;
        sig_clr  = 1'b0;
        if (rsp_ready) st_d.rv = 1'b0;
        if (acc) begin
            st_d.rv    = 1'b1;
            st_d.blk   = 1'b0;
            st_d.rdata = '0;
            unique case (op)
                OP_FUSE_WR: fuse_we = 1'b1;
                OP_FUSE_RD: begin
                    if (st_q.sec) st_d.blk   = 1'b1;
                    else          st_d.rdata = fuse_rdata;
                end
                OP_PRELOAD: begin
                    if (st_q.sec) begin
                        st_d.blk = 1'b1;
                    end else begin
                        st_d.plv   = 1'b1;
                        st_d.plval = cmd_wdata[NREG-1:0];
                    end
                end
                OP_SIG_RD: st_d.rdata = DATA_W'(sig_rdata);
                OP_SIG_WR: sig_we     = 1'b1;
                OP_SECURE: st_d.sec   = 1'b1;
                OP_ERASE: begin
                    st_d.sec = 1'b0;
                    fuse_clr = 1'b1;
                    sig_clr  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid     = st_q.rv;
    assign rsp_data      = st_q.rdata;
    assign rsp_blocked   = st_q.blk;
    assign preload_valid = st_q.plv;
    assign preload_value = st_q.plval;

    // R2
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_blocked));

    // R2
    ready_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |-> rsp_valid && !rsp_ready);

    // R6
    sec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sec && !(acc && op == OP_ERASE) |=> st_q.sec);

    // R8
    preload_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preload_valid |-> !st_q.sec && rsp_valid && !rsp_blocked);

    // R7
    blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_blocked |-> rsp_data == '0);
endmodule

// File: tb/tb_cfgsec_ctrl.sv
module tb_cfgsec_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd7;
    logic [4:0]  cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_data;
    logic        rsp_blocked;
    logic        preload_valid;
    logic [9:0]  preload_value;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cfgsec_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_blocked(rsp_blocked), .preload_valid(preload_valid),
        .preload_value(preload_value)
    );

    // behavioural model
    logic [31:0] mf [32];
    logic [7:0]  ms [8];
    bit          msec = 0;
    bit          m_rv = 0, m_blk = 0, m_plv = 0;
    logic [31:0] m_data = '0;
    logic [9:0]  m_plval = '0;
    string       m_tag = "R1";

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input logic [2:0] op, input logic [4:0] a,
                       input logic [31:0] wd, input bit rr);
        bit er, acc;
        cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_wdata = wd; rsp_ready = rr;
        #1;
        er  = !m_rv || rr;
        acc = v && er;
        chk("R2", "cmd_ready", 64'(cmd_ready), 64'(er));
        m_plv = 0;
        if (rr) m_rv = 0;
        if (acc) begin
            m_rv = 1; m_blk = 0; m_data = '0;
            case (op)
                3'd0: begin m_tag = msec ? "R9" : "R3"; mf[a] = wd; end
                3'd1: begin
                    if (msec) begin m_tag = "R7"; m_blk = 1; end
                    else begin m_tag = "R4"; m_data = mf[a]; end
                end
                3'd2: begin
                    m_tag = "R8";
                    if (msec) m_blk = 1;
                    else begin m_plv = 1; m_plval = wd[9:0]; end
                end
                3'd3: begin m_tag = "R5"; m_data = 32'(ms[a[2:0]]); end
                3'd4: begin m_tag = "R5"; ms[a[2:0]] = wd[7:0]; end
                3'd5: begin m_tag = "R6"; msec = 1; end
                3'd6: begin
                    m_tag = "R10"; msec = 0;
                    for (int i = 0; i < 32; i++) mf[i] = '0;
                    for (int i = 0; i < 8; i++) ms[i] = '0;
                end
                default: m_tag = "R11";
            endcase
        end else if (!m_rv) begin
            m_tag = "R2";
        end
        @(posedge clk);
        @(negedge clk);
        chk(m_tag, "rsp_valid", 64'(rsp_valid), 64'(m_rv));
        if (m_rv) begin
            chk(m_tag, "rsp_data", 64'(rsp_data), 64'(m_data));
            chk(m_tag, "rsp_blocked", 64'(rsp_blocked), 64'(m_blk));
        end
        chk(m_tag, "preload_valid", 64'(preload_valid), 64'(m_plv));
        if (m_plv) chk(m_tag, "preload_value", 64'(preload_value), 64'(m_plval));
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mf[i] = '0;
        for (int i = 0; i < 8; i++) ms[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "preload_valid", 64'(preload_valid), 64'd0);
        chk("R1", "cmd_ready", 64'(cmd_ready), 64'd1);
        cyc(1, 3'd1, 5'd9, 0, 1);  // R1 fuse zero
        cyc(1, 3'd3, 5'd6, 0, 1);  // R1 signature zero
        // R3 / R4
        cyc(1, 3'd0, 5'd0, 32'hDEADBEEF, 1);
        cyc(1, 3'd0, 5'd5, 32'h12345678, 1);
        cyc(1, 3'd0, 5'd31, 32'hFFFF0001, 1);
        cyc(1, 3'd1, 5'd0, 0, 1);
        cyc(1, 3'd1, 5'd5, 0, 1);
        cyc(1, 3'd1, 5'd31, 0, 1);
        // R5
        for (int i = 0; i < 8; i++) cyc(1, 3'd4, 5'(i), 32'hFFFFFFA0 + i, 1);
        cyc(1, 3'd3, 5'd3, 0, 1);
        cyc(1, 3'd3, 5'd15, 0, 1);
        // R8 preload open
        cyc(1, 3'd2, 5'd0, 32'h000002A5, 1);
        // R2 stall, refused offer, then drain and accept together
        cyc(1, 3'd1, 5'd5, 0, 0);
        cyc(1, 3'd1, 5'd31, 0, 0);
        cyc(1, 3'd1, 5'd31, 0, 0);
        cyc(1, 3'd1, 5'd31, 0, 1);
        cyc(0, 3'd0, 5'd0, 0, 1);
        // R11
        cyc(1, 3'd7, 5'd5, 32'h55, 1);
        cyc(1, 3'd1, 5'd5, 0, 1);
        // R6 then immediately blocked R7
        cyc(1, 3'd5, 5'd0, 0, 1);
        cyc(1, 3'd1, 5'd5, 0, 1);
        cyc(1, 3'd2, 5'd0, 32'h3FF, 1);
        cyc(1, 3'd3, 5'd7, 0, 1);
        cyc(1, 3'd0, 5'd2, 32'hCAFE, 1);  // R9
        cyc(1, 3'd1, 5'd2, 0, 1);
        cyc(1, 3'd4, 5'd1, 32'h3C, 1);
        cyc(1, 3'd3, 5'd1, 0, 1);
        cyc(1, 3'd5, 5'd0, 0, 1);
        cyc(1, 3'd1, 5'd0, 0, 1);
        // R10 erase
        cyc(1, 3'd6, 5'd0, 0, 1);
        cyc(1, 3'd1, 5'd5, 0, 1);
        cyc(1, 3'd1, 5'd2, 0, 1);
        cyc(1, 3'd3, 5'd1, 0, 1);
        cyc(1, 3'd2, 5'd0, 32'h0F0, 1);
        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [2:0] o;
            r = $urandom_range(0, 99);
            if (r < 3)       o = 3'd5;
            else if (r < 5)  o = 3'd6;
            else             o = 3'($urandom_range(0, 4));
            if (r > 96) o = 3'd7;
            cyc($urandom_range(0, 3) != 0, o, 5'($urandom_range(0, 31)),
                $urandom, $urandom_range(0, 3) != 0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule